// File: doc/BRIEF.md
# Programmable Logic Macrocell

This block is a single logic cell of a programmable logic array. Five product-term inputs and a cascade input from a neighbouring cell are combined into a sum term. The sum term passes through an XOR stage that sets the polarity or forms a compare function. It then reaches a one-bit storage element. Static configuration inputs choose the behaviour. The storage element can work as a D, T, JK or SR flip-flop, or as a level-sensitive latch. Its clock, clock enable, asynchronous clear and asynchronous set each have several possible sources. The cell drives a pin output, a buried feedback output and a cascade output that carries its sum term to the next cell.

The whole cell runs on one system clock, `clk`. The global clocks and the product-term clock arrive as data and are sampled on `clk`. A rising edge of the selected cell clock is found by comparing its current level with the level held from the previous system cycle. Clear and set act combinationally on the registered view, so their effect is visible in the same cycle, and they also force the stored bit at the next `clk` edge. `por` is a synchronous power-up clear.

The storage element is written as a two-state machine with states ST_LOW and ST_HIGH. The transitions are:
- SET: ST_LOW to ST_HIGH.
- CLEAR: ST_HIGH to ST_LOW.
- TOGGLE: either state to the other.
- HOLD: the state is kept.

The storage mode and its inputs decide which transition is taken. Clear or `por` forces CLEAR. Set forces SET.

Product-term roles, set by parameters:
- pt[0]: XOR operand and preset term.
- pt[1]: dedicated data term.
- pt[2]: K or R input.
- pt[3]: clock term or clock enable.
- pt[4]: reset term.

Top module: `plm_macrocell`

## Requirements
- R1: `cas_out` equals the OR of all `pt[i]` whose `cfg_sum_mask[i]` bit is 1, ORed with `cas_in` when `cfg_cas_en` is 1. Unmasked terms, and `cas_in` while `cfg_cas_en` is 0, have no effect.
- R2: The combinational result is the sum term XORed with an operand chosen by `cfg_xor_sel`. The codes are 0 for constant 0, 1 for constant 1, 2 for pt[0] and 3 for constant 0. It appears on `pin_out` when `cfg_pin_reg` is 0.
- R3: Storage data is chosen by `cfg_d_sel`. The codes are 0 for the XOR result, 1 for pt[1], 2 for `pin_in` and 3 for the XOR result.
- R4: `cfg_mode` 0 (D) loads the data on a rising edge of the cell clock. Mode 1 (T) toggles on that edge when the data is 1 and holds when it is 0. With no rising edge the state holds.
- R5: In mode 2 (JK), J is the data and K is pt[2]: J=1,K=0 sets, J=0,K=1 clears, J=K=1 toggles and J=K=0 holds. In mode 3 (SR), S is the data and R is pt[2]: S only sets, R only clears, and S=R=1 or S=R=0 holds.
- R6: In mode 4 (latch), the registered view equals the data in the same cycle while the cell clock is high. While the cell clock is low it holds the last value captured.
- R7: `cfg_clk_sel` values 0, 1 and 2 select `gclk[0..2]`, and value 3 selects pt[3]. Edges on clocks that are not selected have no effect.
- R8: When a global clock is selected and `cfg_ce_en` is 1, pt[3] acts as clock enable, and edges are ignored while it is 0. When `cfg_ce_en` is 0, every edge counts.
- R9: `cfg_ar_sel` selects the clear source: 0 none, 1 `gclr`, 2 pt[4], 3 `gclr` OR pt[4]. An active clear forces the registered view to 0 in the same cycle and leaves the state at 0 after it is released, even if a clock edge occurred meanwhile.
- R10: With `cfg_ap_en` at 1, pt[0] forces the registered view to 1 at once and leaves the state at 1. When clear and set are both active, clear wins.
- R11: `cfg_pin_reg` and `cfg_fb_reg` independently pick registered (1) or combinational (0) for `pin_out` and `fb_out`.
- R12: `por` clears the state at the next `clk` edge. A cell clock that is already high when `por` is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-up clear, active high |
| pt | input | 5 | Product-term inputs |
| cas_in | input | 1 | Cascade sum from the neighbouring cell |
| gclk | input | 3 | Global clocks, sampled on clk |
| gclr | input | 1 | Global clear |
| pin_in | input | 1 | Pin input level |
| cfg_sum_mask | input | 5 | Product terms included in the sum |
| cfg_cas_en | input | 1 | Include cas_in in the sum |
| cfg_xor_sel | input | 2 | XOR operand select |
| cfg_d_sel | input | 2 | Storage data select |
| cfg_mode | input | 3 | Storage mode |
| cfg_clk_sel | input | 2 | Cell clock select |
| cfg_ce_en | input | 1 | Enable pt[3] as clock enable |
| cfg_ar_sel | input | 2 | Asynchronous clear source |
| cfg_ap_en | input | 1 | Enable pt[0] as asynchronous set |
| cfg_pin_reg | input | 1 | Pin output registered (1) or combinational (0) |
| cfg_fb_reg | input | 1 | Feedback registered (1) or combinational (0) |
| pin_out | output | 1 | Pin output |
| fb_out | output | 1 | Buried feedback |
| cas_out | output | 1 | Sum term to the next cell |

## Verification
The bench goes after corner cases that a faulty cell would get wrong.
- Both J and K high must toggle. A cell that treats J=K=1 like the SR case would hold instead.
- Clear and set asserted together must give 0. Reversed priority would read 1.
- A clock edge that arrives while clear is held must not survive the release. A cell that loads on that edge would come back as 1.
- A cell clock still high when power-up clear ends must not be taken as a new edge. Otherwise the cell would capture data straight after reset.
- Switching the clock select must leave edges on the old clock ignored, and a low clock enable must block edges only under a global clock.
- Latch mode must pass data within the same cycle while its gate is high. A design that waits for an edge would lag by one cycle.

// File: rtl/plm_pkg.sv
package plm_pkg;

    typedef enum logic [2:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4
    } store_mode_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } bit_state_e;

    typedef enum logic [1:0] {
        XOP_ZERO  = 2'd0,
        XOP_ONE   = 2'd1,
        XOP_PTERM = 2'd2,
        XOP_RSVD  = 2'd3
    } xor_op_e;

    typedef enum logic [1:0] {
        DSRC_XOR  = 2'd0,
        DSRC_PT   = 2'd1,
        DSRC_PIN  = 2'd2,
        DSRC_RSVD = 2'd3
    } dsrc_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'd0,
        CLR_GLB  = 2'd1,
        CLR_PT   = 2'd2,
        CLR_BOTH = 2'd3
    } clr_src_e;

endpackage

// File: rtl/plm_sum_xor.sv
module plm_sum_xor
    import plm_pkg::*;
#(
    parameter int NPT     = 5,
    parameter int XOR_PT  = 0,
    parameter int DATA_PT = 1
) (
    input  logic [NPT-1:0] pt,
    input  logic [NPT-1:0] mask,
    input  logic           cas_en,
    input  logic           cas_in,
    input  xor_op_e        xor_sel,
    input  dsrc_e          d_sel,
    input  logic           pin_in,
    output logic           sum,
    output logic           xor_out,
    output logic           d
);

    logic [NPT-1:0] term_g;
    logic           operand;

    for (genvar g = 0; g < NPT; g++) begin : g_term
        assign term_g[g] = pt[g] & mask[g];
    end

    assign sum = (|term_g) | (cas_en & cas_in);

    always_comb begin
        unique case (xor_sel)
            XOP_ONE:   operand = 1'b1;
            XOP_PTERM: operand = pt[XOR_PT];
            default:   operand = 1'b0;
        endcase
    end

    assign xor_out = sum ^ operand;

    always_comb begin
        unique case (d_sel)
            DSRC_PT:  d = pt[DATA_PT];
            DSRC_PIN: d = pin_in;
            default:  d = xor_out;
        endcase
    end

endmodule

// File: rtl/plm_ctrl_sel.sv
module plm_ctrl_sel
    import plm_pkg::*;
#(
    parameter int NGCLK = 3
) (
    input  logic [NGCLK-1:0]             gclk,
    input  logic                         gclr,
    input  logic                         pt_clk,
    input  logic                         pt_ar,
    input  logic                         pt_ap,
    input  logic [$clog2(NGCLK+1)-1:0]   clk_sel,
    input  logic                         ce_en,
    input  clr_src_e                     ar_sel,
    input  logic                         ap_en,
    output logic                         cell_clk,
    output logic                         ce,
    output logic                         ar,
    output logic                         ap
);

    localparam int CSW = $clog2(NGCLK+1);

    logic is_global;

    always_comb begin
        cell_clk = pt_clk;
        for (int i = 0; i < NGCLK; i++) begin
            if (clk_sel == CSW'(i)) cell_clk = gclk[i];
        end
    end

    assign is_global = (clk_sel < CSW'(NGCLK));
    assign ce        = ~(is_global & ce_en) | pt_clk;

    always_comb begin
        unique case (ar_sel)
            CLR_GLB:  ar = gclr;
            CLR_PT:   ar = pt_ar;
            CLR_BOTH: ar = gclr | pt_ar;
            default:  ar = 1'b0;
        endcase
    end

    assign ap = ap_en & pt_ap;

endmodule

// File: rtl/plm_store.sv
module plm_store
    import plm_pkg::*;
(
    input  logic        clk,
    input  logic        por,
    input  store_mode_e mode,
    input  logic        d,
    input  logic        k_r,
    input  logic        cell_clk,
    input  logic        ce,
    input  logic        ar,
    input  logic        ap,
    output logic        q_view
);

    bit_state_e st, nxt;
    logic       clk_q;
    logic       rise;
    logic       fire;

    assign rise = cell_clk & ~clk_q;
    assign fire = rise & ce;

    // state register process
    always_ff @(posedge clk) begin
        clk_q <= cell_clk;
        if (por) st <= ST_LOW;
        else     st <= nxt;
    end

    // transition process: SET, CLEAR, TOGGLE, HOLD
    always_comb begin
        nxt = st;
        if (ar) begin
            nxt = ST_LOW;
        end else if (ap) begin
            nxt = ST_HIGH;
        end else begin
            unique case (mode)
                MODE_LATCH: if (cell_clk) nxt = bit_state_e'(d);
                MODE_T: begin
                    if (fire && d) nxt = (st == ST_HIGH) ? ST_LOW : ST_HIGH;
                end
                MODE_JK: begin
                    if (fire) begin
                        unique case ({d, k_r})
                            2'b10:   nxt = ST_HIGH;
                            2'b01:   nxt = ST_LOW;
                            2'b11:   nxt = (st == ST_HIGH) ? ST_LOW : ST_HIGH;
                            default: nxt = st;
                        endcase
                    end
                end
                MODE_SR: begin
                    if (fire) begin
                        unique case ({d, k_r})
                            2'b10:   nxt = ST_HIGH;
                            2'b01:   nxt = ST_LOW;
                            default: nxt = st;
                        endcase
                    end
                end
                default: if (fire) nxt = bit_state_e'(d);
            endcase
        end
    end

    // output process
    always_comb begin
        if (ar)                                 q_view = 1'b0;
        else if (ap)                            q_view = 1'b1;
        else if (mode == MODE_LATCH && cell_clk) q_view = d;
        else                                    q_view = (st == ST_HIGH);
    end

    AST_CLEAR_FORCES_LOW: assert property (@(posedge clk) disable iff (por)
        ar |=> st == ST_LOW); // R9
    AST_SET_FORCES_HIGH: assert property (@(posedge clk) disable iff (por)
        (ap && !ar) |=> st == ST_HIGH); // R10
    AST_NO_EDGE_HOLDS: assert property (@(posedge clk) disable iff (por)
        (mode != MODE_LATCH && !ar && !ap && !rise) |=> $stable(st)); // R4
    AST_CE_BLOCKS_EDGE: assert property (@(posedge clk) disable iff (por)
        (mode != MODE_LATCH && !ar && !ap && !ce) |=> $stable(st)); // R8
    AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (por)
        (mode == MODE_LATCH && cell_clk && !ar && !ap) |=> st == bit_state_e'($past(d))); // R6
    AST_JK_TOGGLES: assert property (@(posedge clk) disable iff (por)
        (mode == MODE_JK && fire && d && k_r && !ar && !ap) |=> st != $past(st)); // R5

endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell
    import plm_pkg::*;
#(
    parameter int NPT     = 5,
    parameter int NGCLK   = 3,
    parameter int XOR_PT  = 0,
    parameter int DATA_PT = 1,
    parameter int KR_PT   = 2,
    parameter int CLK_PT  = 3,
    parameter int AR_PT   = 4,
    parameter int AP_PT   = 0
) (
    input  logic                        clk,
    input  logic                        por,
    input  logic [NPT-1:0]              pt,
    input  logic                        cas_in,
    input  logic [NGCLK-1:0]            gclk,
    input  logic                        gclr,
    input  logic                        pin_in,
    input  logic [NPT-1:0]              cfg_sum_mask,
    input  logic                        cfg_cas_en,
    input  logic [1:0]                  cfg_xor_sel,
    input  logic [1:0]                  cfg_d_sel,
    input  logic [2:0]                  cfg_mode,
    input  logic [$clog2(NGCLK+1)-1:0]  cfg_clk_sel,
    input  logic                        cfg_ce_en,
    input  logic [1:0]                  cfg_ar_sel,
    input  logic                        cfg_ap_en,
    input  logic                        cfg_pin_reg,
    input  logic                        cfg_fb_reg,
    output logic                        pin_out,
    output logic                        fb_out,
    output logic                        cas_out
);

    logic sum, xor_out, d;
    logic cell_clk, ce, ar, ap;
    logic q_view;

    plm_sum_xor #(
        .NPT    (NPT),
        .XOR_PT (XOR_PT),
        .DATA_PT(DATA_PT)
    ) u_sum_xor (
        .pt     (pt),
        .mask   (cfg_sum_mask),
        .cas_en (cfg_cas_en),
        .cas_in (cas_in),
        .xor_sel(xor_op_e'(cfg_xor_sel)),
        .d_sel  (dsrc_e'(cfg_d_sel)),
        .pin_in (pin_in),
        .sum    (sum),
        .xor_out(xor_out),
        .d      (d)
    );

    plm_ctrl_sel #(
        .NGCLK(NGCLK)
    ) u_ctrl_sel (
        .gclk    (gclk),
        .gclr    (gclr),
        .pt_clk  (pt[CLK_PT]),
        .pt_ar   (pt[AR_PT]),
        .pt_ap   (pt[AP_PT]),
        .clk_sel (cfg_clk_sel),
        .ce_en   (cfg_ce_en),
        .ar_sel  (clr_src_e'(cfg_ar_sel)),
        .ap_en   (cfg_ap_en),
        .cell_clk(cell_clk),
        .ce      (ce),
        .ar      (ar),
        .ap      (ap)
    );

    plm_store u_store (
        .clk     (clk),
        .por     (por),
        .mode    (store_mode_e'(cfg_mode)),
        .d       (d),
        .k_r     (pt[KR_PT]),
        .cell_clk(cell_clk),
        .ce      (ce),
        .ar      (ar),
        .ap      (ap),
        .q_view  (q_view)
    );

    assign cas_out = sum;
    assign pin_out = cfg_pin_reg ? q_view : xor_out;
    assign fb_out  = cfg_fb_reg  ? q_view : xor_out;

    AST_SAME_VIEW_MATCH: assert property (@(posedge clk) disable iff (por)
        (cfg_pin_reg == cfg_fb_reg) |-> pin_out == fb_out); // R11
    AST_POR_CLEARS: assert property (@(posedge clk)
        (por && !cfg_ap_en) |=> !(cfg_pin_reg && cfg_fb_reg && !ap && !(cfg_mode == 3'd4 && cell_clk)) || !fb_out); // R12

endmodule

// File: tb/plm_macrocell_bench.sv
`timescale 1ns/100ps
module plm_macrocell_bench;

    logic       clk = 1'b0;
    logic       por;
    logic [4:0] pt;
    logic       cas_in;
    logic [2:0] gclk;
    logic       gclr;
    logic       pin_in;
    logic [4:0] cfg_sum_mask;
    logic       cfg_cas_en;
    logic [1:0] cfg_xor_sel;
    logic [1:0] cfg_d_sel;
    logic [2:0] cfg_mode;
    logic [1:0] cfg_clk_sel;
    logic       cfg_ce_en;
    logic [1:0] cfg_ar_sel;
    logic       cfg_ap_en;
    logic       cfg_pin_reg;
    logic       cfg_fb_reg;
    logic       pin_out, fb_out, cas_out;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    plm_macrocell u_plm_macrocell (
        .clk(clk), .por(por), .pt(pt), .cas_in(cas_in), .gclk(gclk),
        .gclr(gclr), .pin_in(pin_in), .cfg_sum_mask(cfg_sum_mask),
        .cfg_cas_en(cfg_cas_en), .cfg_xor_sel(cfg_xor_sel), .cfg_d_sel(cfg_d_sel),
        .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_ce_en(cfg_ce_en),
        .cfg_ar_sel(cfg_ar_sel), .cfg_ap_en(cfg_ap_en), .cfg_pin_reg(cfg_pin_reg),
        .cfg_fb_reg(cfg_fb_reg), .pin_out(pin_out), .fb_out(fb_out), .cas_out(cas_out)
    );

    // driver side: push expectation {pin, fb, cas}
    task automatic chk(input logic p, input logic f, input logic c, input string tag);
        exp_q.push_back({p, f, c});
        tag_q.push_back(tag);
    endtask

    task automatic go();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int i);
        gclk[i] = 1'b1;
        go();
        gclk[i] = 1'b0;
        go();
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            logic [2:0] e, got;
            string      t;
            wait (exp_q.size() != 0);
            #0.5;
            e   = exp_q.pop_front();
            t   = tag_q.pop_front();
            got = {pin_out, fb_out, cas_out};
            n_vec++;
            if (got !== e) begin
                n_bad++;
                $display("FAIL %s: pin/fb/cas actual %b expected %b", t, got, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        por = 1'b1; pt = '0; cas_in = 0; gclk = '0; gclr = 0; pin_in = 0;
        cfg_sum_mask = '0; cfg_cas_en = 0; cfg_xor_sel = 0; cfg_d_sel = 0;
        cfg_mode = 0; cfg_clk_sel = 0; cfg_ce_en = 0; cfg_ar_sel = 0;
        cfg_ap_en = 0; cfg_pin_reg = 0; cfg_fb_reg = 1;
        go(); go();
        por = 1'b0;
        chk(0, 0, 0, "R12 reset state");

        // R1 sum term and cascade
        go(); cfg_sum_mask = 5'b10110; pt = 5'b00100;
        chk(1, 0, 1, "R1 masked term");
        go(); pt = 5'b01001;
        chk(0, 0, 0, "R1 unmasked terms ignored");
        go(); pt = 5'b00000; cfg_cas_en = 1; cas_in = 1;
        chk(1, 0, 1, "R1 cascade enabled");
        go(); cfg_cas_en = 0;
        chk(0, 0, 0, "R1 cascade disabled");

        // R2 XOR operand
        go(); cas_in = 0; cfg_sum_mask = 5'b00000; cfg_xor_sel = 1;
        chk(1, 0, 0, "R2 constant one inverts");
        go(); cfg_xor_sel = 2; cfg_sum_mask = 5'b00010; pt = 5'b00011;
        chk(0, 0, 1, "R2 pterm operand cancels");
        go(); pt = 5'b00010;
        chk(1, 0, 1, "R2 pterm operand low");
        go(); cfg_xor_sel = 0; cfg_sum_mask = 5'b00000; pt = 5'b00000;

        // R4 D and T
        cfg_mode = 0; cfg_d_sel = 1; pt = 5'b00010;
        pulse(0); chk(0, 1, 0, "R4 D loads one");
        go(); pt = 5'b00000; go();
        chk(0, 1, 0, "R4 no edge holds");
        pulse(0); chk(0, 0, 0, "R4 D loads zero");
        go(); cfg_mode = 1; pt = 5'b00010;
        pulse(0); chk(0, 1, 0, "R4 T toggles up");
        pulse(0); chk(0, 0, 0, "R4 T toggles down");
        go(); pt = 5'b00000;
        pulse(0); chk(0, 0, 0, "R4 T zero holds");

        // R3 data select
        go(); cfg_mode = 0; cfg_d_sel = 2; pin_in = 1;
        pulse(0); chk(0, 1, 0, "R3 pin data");
        go(); cfg_d_sel = 0; cfg_sum_mask = 5'b00001; pt = 5'b00000;
        pulse(0); chk(0, 0, 0, "R3 xor data zero");
        go(); pt = 5'b00001;
        pulse(0); chk(1, 1, 1, "R3 xor data one");
        go(); cfg_sum_mask = 5'b00000; pt = 5'b00000; cfg_d_sel = 1;
        pulse(0); chk(0, 0, 0, "R3 pterm data, pin ignored");
        go(); pin_in = 0;

        // R5 JK then SR (bit1 = J/S, bit2 = K/R)
        cfg_mode = 2; pt = 5'b00010;
        pulse(0); chk(0, 1, 0, "R5 JK set");
        go(); pt = 5'b00000;
        pulse(0); chk(0, 1, 0, "R5 JK hold");
        go(); pt = 5'b00110;
        pulse(0); chk(0, 0, 0, "R5 JK toggle down");
        pulse(0); chk(0, 1, 0, "R5 JK toggle up");
        go(); pt = 5'b00100;
        pulse(0); chk(0, 0, 0, "R5 JK clear");
        go(); cfg_mode = 3; pt = 5'b00010;
        pulse(0); chk(0, 1, 0, "R5 SR set");
        go(); pt = 5'b00110;
        pulse(0); chk(0, 1, 0, "R5 SR both high holds one");
        go(); pt = 5'b00100;
        pulse(0); chk(0, 0, 0, "R5 SR clear");
        go(); pt = 5'b00110;
        pulse(0); chk(0, 0, 0, "R5 SR both high holds zero");
        go(); pt = 5'b00000;

        // R6 latch
        cfg_mode = 4; pt = 5'b00010;
        go(); chk(0, 0, 0, "R6 gate low holds");
        go(); gclk[0] = 1;
        chk(0, 1, 0, "R6 transparent same cycle");
        go(); pt = 5'b00000;
        chk(0, 0, 0, "R6 follows data");
        go(); pt = 5'b00010;
        go(); gclk[0] = 0; pt = 5'b00000;
        chk(0, 1, 0, "R6 holds on gate low");
        go(); chk(0, 1, 0, "R6 still holds");
        go(); cfg_mode = 0;

        // R7 clock select
        cfg_clk_sel = 1; pt = 5'b00000;
        pulse(0); chk(0, 1, 0, "R7 unselected clock ignored");
        pulse(1); chk(0, 0, 0, "R7 gclk1 selected");
        go(); pt = 5'b00010; cfg_clk_sel = 3;
        pulse(1); chk(0, 0, 0, "R7 gclk ignored under pterm clock");
        go(); pt = 5'b01010; go(); pt = 5'b00010; go();
        chk(0, 1, 0, "R7 pterm clock edge");

        // R8 clock enable
        go(); cfg_clk_sel = 2; cfg_ce_en = 1; pt = 5'b00000;
        pulse(2); chk(0, 1, 0, "R8 enable low ignores edge");
        go(); pt = 5'b01000;
        pulse(2); chk(0, 0, 0, "R8 enable high passes edge");
        go(); cfg_ce_en = 0; pt = 5'b00010;
        pulse(2); chk(0, 1, 0, "R8 enable off");
        go(); cfg_clk_sel = 0;

        // R9 clear sources
        cfg_pin_reg = 1; gclr = 1;
        chk(1, 1, 0, "R9 gclr unselected");
        go(); gclr = 0; go(); cfg_ar_sel = 1; gclr = 1;
        chk(0, 0, 0, "R9 gclr immediate");
        go(); gclr = 0; go();
        chk(0, 0, 0, "R9 state cleared");
        go(); gclr = 1;
        pulse(0); gclr = 0; go();
        chk(0, 0, 0, "R9 clear blocks edge");
        go(); cfg_ar_sel = 2;
        pulse(0); chk(1, 1, 0, "R9 load before pterm clear");
        go(); pt = 5'b10010;
        chk(0, 0, 0, "R9 pterm clear immediate");
        go(); pt = 5'b00010; go();
        chk(0, 0, 0, "R9 pterm clear leaves zero");
        go(); cfg_ar_sel = 3;
        pulse(0); go(); gclr = 1;
        chk(0, 0, 0, "R9 either: gclr");
        go(); gclr = 0;
        pulse(0); go(); pt = 5'b10010;
        chk(0, 0, 0, "R9 either: pterm");
        go(); pt = 5'b00000; cfg_ar_sel = 0; go();

        // R10 preset
        cfg_ap_en = 1; pt = 5'b00001;
        chk(1, 1, 0, "R10 preset immediate");
        go(); pt = 5'b00000; go();
        chk(1, 1, 0, "R10 preset held");
        go(); cfg_ar_sel = 1; gclr = 1; pt = 5'b00001;
        chk(0, 0, 0, "R10 clear wins over preset");
        go(); gclr = 0; pt = 5'b00000; go();
        chk(0, 0, 0, "R10 zero after both");
        go(); cfg_ar_sel = 0; cfg_ap_en = 0; pt = 5'b00001; go();
        chk(0, 0, 0, "R10 preset disabled");

        // R11 independent output views
        go(); cfg_sum_mask = 5'b00001; cfg_pin_reg = 0; cfg_fb_reg = 1;
        chk(1, 0, 1, "R11 pin comb, fb registered");
        go(); cfg_pin_reg = 1; cfg_fb_reg = 0;
        chk(0, 1, 1, "R11 pin registered, fb comb");
        go(); cfg_sum_mask = 5'b00000; pt = 5'b00000; cfg_pin_reg = 0; cfg_fb_reg = 1;

        // R12 power-up clear with clock already high
        pt = 5'b00010;
        pulse(0); chk(0, 1, 0, "R12 loaded before por");
        go(); por = 1; gclk[0] = 1;
        go(); chk(0, 0, 0, "R12 por clears");
        por = 0;
        go(); chk(0, 0, 0, "R12 no false edge after por");
        gclk[0] = 0; go(); gclk[0] = 1; go();
        chk(0, 1, 0, "R12 real edge after por");
        go(); gclk[0] = 0;

        wait (exp_q.size() == 0);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule